// File: doc/BRIEF.md
# Snooping MSI Cache-Line Controller

This block keeps a small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Each line stores a tag, one data word and a coherence state. The state is Invalid, Shared (clean and read-only) or Modified (dirty and writable). The line state changes for two reasons: requests from the local processor, and miss transactions from other caches that this block watches on the bus. On a local miss the block asks an external arbiter for the bus. It then writes back a dirty victim if one is in the way, places a read miss or a write miss, and keeps the bus until the fill word returns. Because only one cache owns the bus at a time, writes to any line are serialized.

Processor requests enter through a valid/ready handshake and leave through a response that is only a valid pulse. The snoop side is plain. A watched transaction lasts one cycle. If this cache holds the line Modified, it raises a "supplied" flag and puts the line's word on the bus in the same cycle, so that memory is overridden. The backing memory, the arbiter and the peer caches are outside the block.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. `bus_req` and `cpu_rsp_valid` are low and `cpu_req_ready` is high, so the first access to any address misses.
- R2: A processor read whose line is Invalid or holds another tag places exactly one read miss (op code 1) with the request address. It returns the word from `bus_rsp_data` and leaves the line Shared.
- R3: A processor write to a line that is Invalid, Shared or holds another tag places a write miss (op code 2) carrying the address and the write word. After the fill response the line is Modified with that word.
- R4: When a miss finds its line Modified under a different tag, the block first issues one writeback (op code 3) with the old line address and word. The miss follows in the next cycle.
- R5: A read to a Shared or Modified line with a matching tag, or a write to a Modified line with a matching tag, completes with no bus transaction. `cpu_rsp_valid` is high in the cycle after acceptance, and a read returns the stored word.
- R6: A watched write miss (op 2) whose tag matches a Shared line invalidates that line, and `snp_supply` stays low.
- R7: A watched read miss (op 1) that matches a Modified line raises `snp_supply` with the line's word in the same cycle, and the line becomes Shared.
- R8: A watched write miss that matches a Modified line raises `snp_supply` with the line's word in the same cycle, and the line becomes Invalid.
- R9: A watched transaction that matches no valid line, a read miss to a Shared line, and any watched writeback (op 3) change no state and leave `snp_supply` low.
- R10: The block drives `bus_out_valid` only while it holds `bus_gnt`. It keeps `bus_req` high from the request until the fill arrives. The writeback decision is taken when the grant arrives, so a watched transaction that lands while the request waits is taken into account.
- R11: `cpu_req_ready` is low while a miss is in flight and in any cycle with `snp_valid` high, so only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request accepted when high together with valid |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address: low IDX_W bits are the index, the rest the tag |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse, cannot be stalled |
| cpu_rsp_rdata | output | DATA_W | Read word (echo of the write word for writes) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_out_valid | output | 1 | Transaction driven by this cache this cycle |
| bus_out_op | output | 2 | 1 read miss, 2 write miss, 3 writeback |
| bus_out_addr | output | ADDR_W | Transaction line address |
| bus_out_data | output | DATA_W | Writeback word or write-miss word |
| bus_rsp_valid | input | 1 | Fill word for this cache's miss |
| bus_rsp_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | Transaction from another cache this cycle |
| snp_op | input | 2 | Op code of the watched transaction |
| snp_addr | input | ADDR_W | Address of the watched transaction |
| snp_supply | output | 1 | This cache owns the line and supplies it |
| snp_data | output | DATA_W | Supplied word, zero when not supplying |

## Verification
The assertions assume the following about the inputs. Once the arbiter grants the bus it keeps the grant while `bus_req` stays high. No watched transaction appears in a cycle when this cache holds the grant. The fill response arrives no earlier than the cycle after the miss. The bench enforces these rules through its bus model: the grant follows the request with one cycle of delay, and snoops are injected only while the grant is low. The random mix draws from four tags and eight indexes so that victims, sharing conflicts and snoop hits occur often. One directed case holds the grant back and injects a read miss against the dirty victim while the request waits.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LN_I = 2'd0,
    LN_S = 2'd1,
    LN_M = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_RDMISS = 2'd1,
    OP_WRMISS = 2'd2,
    OP_WB     = 2'd3
  } bus_op_t;

  typedef enum logic [2:0] {
    C_IDLE,
    C_ARB,
    C_WB,
    C_MISS,
    C_WAIT
  } ctl_st_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_dat,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_dat,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  line_st_t          cw_st,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic [DATA_W-1:0] cw_dat,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_t          sw_st
);
  logic [LINES*2-1:0]      st_flat;
  logic [LINES*TAG_W-1:0]  tag_flat;
  logic [LINES*DATA_W-1:0] dat_flat;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] dat_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= LN_I;
        tag_r <= '0;
        dat_r <= '0;
      end else if (cw_en && cw_idx == IDX_W'(g)) begin
        st_r  <= cw_st;
        tag_r <= cw_tag;
        dat_r <= cw_dat;
      end else if (sw_en && sw_idx == IDX_W'(g)) begin
        st_r  <= sw_st;
      end
    end
    assign st_flat[g*2 +: 2]          = st_r;
    assign tag_flat[g*TAG_W +: TAG_W]  = tag_r;
    assign dat_flat[g*DATA_W +: DATA_W] = dat_r;
  end

  assign a_st  = line_st_t'(st_flat[a_idx*2 +: 2]);
  assign a_tag = tag_flat[a_idx*TAG_W +: TAG_W];
  assign a_dat = dat_flat[a_idx*DATA_W +: DATA_W];
  assign b_st  = line_st_t'(st_flat[b_idx*2 +: 2]);
  assign b_tag = tag_flat[b_idx*TAG_W +: TAG_W];
  assign b_dat = dat_flat[b_idx*DATA_W +: DATA_W];

  // R11: processor-side and snoop-side updates never collide
  p_port_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cw_en && sw_en));
  // R6/R8: a snoop invalidation is visible on the lookup port next cycle
  p_snoop_inval_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && sw_st == LN_I) |=> (b_st == LN_I || $past(b_idx) != b_idx));
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  ln_idx,
  input  line_st_t          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_dat,
  output logic              supply,
  output logic [DATA_W-1:0] supply_dat,
  output logic              upd_en,
  output line_st_t          upd_st
);
  logic match;

  assign ln_idx = snp_addr[IDX_W-1:0];
  assign match  = snp_valid && ln_st != LN_I && ln_tag == snp_addr[ADDR_W-1:IDX_W];

  always_comb begin
    supply = 1'b0;
    upd_en = 1'b0;
    upd_st = ln_st;
    case (bus_op_t'(snp_op))
      OP_RDMISS: if (match && ln_st == LN_M) begin
        supply = 1'b1;
        upd_en = 1'b1;
        upd_st = LN_S;
      end
      OP_WRMISS: if (match) begin
        supply = (ln_st == LN_M);
        upd_en = 1'b1;
        upd_st = LN_I;
      end
      default: ;
    endcase
  end

  assign supply_dat = supply ? ln_dat : '0;
endmodule

// File: rtl/msi_cpu_ctrl.sv
module msi_cpu_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              snp_valid,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_out_valid,
  output logic [1:0]        bus_out_op,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [DATA_W-1:0] bus_out_data,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_data,
  output logic [IDX_W-1:0]  lk_idx,
  input  line_st_t          lk_st,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [DATA_W-1:0] lk_dat,
  output logic              wr_en,
  output line_st_t          wr_st,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_dat
);
  ctl_st_t           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_q, rsp_set;
  logic [DATA_W-1:0] rsp_dat_q, rsp_dat;
  logic              fire, hit;
  logic [TAG_W-1:0]  req_tag, q_tag;

  assign cpu_req_ready = (st_q == C_IDLE) && !snp_valid;
  assign fire    = cpu_req_valid && cpu_req_ready;
  assign req_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign q_tag   = addr_q[ADDR_W-1:IDX_W];
  assign lk_idx  = (st_q == C_IDLE) ? cpu_req_addr[IDX_W-1:0] : addr_q[IDX_W-1:0];
  assign hit     = lk_st != LN_I && lk_tag == req_tag && (!cpu_req_write || lk_st == LN_M);
  assign bus_req = (st_q != C_IDLE);

  always_comb begin
    st_d          = st_q;
    wr_en         = 1'b0;
    wr_st         = lk_st;
    wr_tag        = lk_tag;
    wr_dat        = lk_dat;
    bus_out_valid = 1'b0;
    bus_out_op    = OP_NONE;
    bus_out_addr  = '0;
    bus_out_data  = '0;
    rsp_set       = 1'b0;
    rsp_dat       = '0;
    case (st_q)
      C_IDLE: if (fire) begin
        if (hit) begin
          rsp_set = 1'b1;
          rsp_dat = cpu_req_write ? cpu_req_wdata : lk_dat;
          if (cpu_req_write) begin
            wr_en  = 1'b1;
            wr_st  = LN_M;
            wr_dat = cpu_req_wdata;
          end
        end else begin
          st_d = C_ARB;
        end
      end
      C_ARB: if (bus_gnt) begin
        st_d = (lk_st == LN_M && lk_tag != q_tag) ? C_WB : C_MISS;
      end
      C_WB: begin
        bus_out_valid = 1'b1;
        bus_out_op    = OP_WB;
        bus_out_addr  = {lk_tag, addr_q[IDX_W-1:0]};
        bus_out_data  = lk_dat;
        wr_en         = 1'b1;
        wr_st         = LN_I;
        st_d          = C_MISS;
      end
      C_MISS: begin
        bus_out_valid = 1'b1;
        bus_out_op    = wr_q ? OP_WRMISS : OP_RDMISS;
        bus_out_addr  = addr_q;
        bus_out_data  = wr_q ? wdata_q : '0;
        st_d          = C_WAIT;
      end
      C_WAIT: if (bus_rsp_valid) begin
        wr_en   = 1'b1;
        wr_tag  = q_tag;
        wr_st   = wr_q ? LN_M : LN_S;
        wr_dat  = wr_q ? wdata_q : bus_rsp_data;
        rsp_set = 1'b1;
        rsp_dat = wr_q ? wdata_q : bus_rsp_data;
        st_d    = C_IDLE;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= C_IDLE;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      rsp_q     <= 1'b0;
      rsp_dat_q <= '0;
    end else begin
      st_q  <= st_d;
      rsp_q <= rsp_set;
      if (rsp_set) rsp_dat_q <= rsp_dat;
      if (fire) begin
        addr_q  <= cpu_req_addr;
        wr_q    <= cpu_req_write;
        wdata_q <= cpu_req_wdata;
      end
    end
  end

  assign cpu_rsp_valid = rsp_q;
  assign cpu_rsp_rdata = rsp_dat_q;

  // R11: a watched transaction always blocks new processor requests
  p_ready_snoop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready);
  // R10: after placing a miss the bus is still held while the fill is awaited
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out_valid && bus_out_op != OP_WB) |=> bus_req);
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_out_valid,
  output logic [1:0]        bus_out_op,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [DATA_W-1:0] bus_out_data,
  input  logic              bus_rsp_valid,
  input  logic [DATA_W-1:0] bus_rsp_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx, sn_idx;
  line_st_t          lk_st, sn_st, wr_st, upd_st;
  logic [TAG_W-1:0]  lk_tag, sn_tag, wr_tag;
  logic [DATA_W-1:0] lk_dat, sn_dat, wr_dat;
  logic              wr_en, upd_en;

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(lk_idx), .a_st(lk_st), .a_tag(lk_tag), .a_dat(lk_dat),
    .b_idx(sn_idx), .b_st(sn_st), .b_tag(sn_tag), .b_dat(sn_dat),
    .cw_en(wr_en), .cw_idx(lk_idx), .cw_st(wr_st), .cw_tag(wr_tag), .cw_dat(wr_dat),
    .sw_en(upd_en), .sw_idx(sn_idx), .sw_st(upd_st)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .ln_idx(sn_idx), .ln_st(sn_st), .ln_tag(sn_tag), .ln_dat(sn_dat),
    .supply(snp_supply), .supply_dat(snp_data),
    .upd_en(upd_en), .upd_st(upd_st)
  );

  msi_cpu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .snp_valid(snp_valid),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_out_valid(bus_out_valid), .bus_out_op(bus_out_op),
    .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
    .lk_idx(lk_idx), .lk_st(lk_st), .lk_tag(lk_tag), .lk_dat(lk_dat),
    .wr_en(wr_en), .wr_st(wr_st), .wr_tag(wr_tag), .wr_dat(wr_dat)
  );

  // R10: transactions only under a held grant
  p_out_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_out_valid |-> (bus_gnt && bus_req));
  // R10: input rule, no peer transaction while this cache owns the bus
  p_no_snoop_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_valid && bus_gnt));
  // R4: a writeback is always followed at once by the miss
  p_wb_then_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out_valid && bus_out_op == OP_WB) |=> (bus_out_valid && bus_out_op != OP_WB));
  // R7/R8: supplying only answers a watched miss
  p_supply_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && snp_op != OP_WB && snp_op != OP_NONE));
endmodule

// File: tb/tb_msi_cache_ctrl.sv
module tb_msi_cache_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [15:0] cpu_rsp_rdata;
  logic        bus_req, bus_out_valid;
  logic        bus_gnt = 1'b0, bus_rsp_valid = 1'b0;
  logic [15:0] bus_rsp_data = '0;
  logic [1:0]  bus_out_op;
  logic [7:0]  bus_out_addr;
  logic [15:0] bus_out_data;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_op = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_supply;
  logic [15:0] snp_data;
  logic        hold_gnt = 1'b0;

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;
  logic [15:0] mem [256];
  logic [1:0]  ref_st [8];
  logic [4:0]  ref_tag [8];
  logic [15:0] ref_dat [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_cache_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_out_valid(bus_out_valid), .bus_out_op(bus_out_op),
    .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_data(snp_data)
  );

  // bus model: grant follows request, fill follows a miss by one cycle
  always @(posedge clk) begin
    bus_gnt       <= rst_n && bus_req && !hold_gnt;
    bus_rsp_valid <= bus_out_valid && (bus_out_op == 2'd1 || bus_out_op == 2'd2);
    bus_rsp_data  <= mem[bus_out_addr];
  end

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt == 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic cpu_op(input bit wr, input logic [7:0] a, input logic [15:0] wd);
    logic [2:0]  ix = a[2:0];
    logic [4:0]  tg = a[7:3];
    bit hit, exp_wb = 0, seen_gnt = 0, seen_req = 0, req_drop = 0;
    int nt = 0, cyc = 1, k = 0;
    logic [1:0]  ops [4];
    logic [7:0]  ads [4];
    logic [15:0] dts [4];
    logic [7:0]  wba = '0;
    logic [15:0] wbd = '0, rd;
    hit = ref_st[ix] != 2'd0 && ref_tag[ix] == tg && (!wr || ref_st[ix] == 2'd2);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    #1;
    chk(cpu_req_ready, "R11 ready when idle", {31'b0, cpu_req_ready}, 1);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (cpu_rsp_valid) break;
      if (bus_gnt && !seen_gnt) begin
        seen_gnt = 1;
        exp_wb = ref_st[ix] == 2'd2 && ref_tag[ix] != tg;
        wba = {ref_tag[ix], ix};
        wbd = ref_dat[ix];
      end
      if (bus_req) seen_req = 1; else if (seen_req) req_drop = 1;
      if (bus_out_valid && nt < 4) begin
        ops[nt] = bus_out_op; ads[nt] = bus_out_addr; dts[nt] = bus_out_data; nt++;
      end
      @(negedge clk);
      cyc++;
    end
    rd = cpu_rsp_rdata;
    chk(cpu_rsp_valid, "R10 response arrives", {31'b0, cpu_rsp_valid}, 1);
    if (hit) begin
      chk(cyc == 1, "R5 hit latency", cyc, 1);
      chk(nt == 0, "R5 hit bus silence", nt, 0);
      if (!wr) chk(rd == ref_dat[ix], "R5 hit data", rd, ref_dat[ix]);
      else ref_dat[ix] = wd;
    end else begin
      chk(seen_gnt && !req_drop, "R10 bus held", {30'b0, seen_gnt, req_drop}, 2);
      chk(nt == (exp_wb ? 2 : 1), "R4 transaction count", nt, exp_wb ? 2 : 1);
      if (exp_wb && nt > 0) begin
        chk(ops[0] == 2'd3, "R4 writeback op", ops[0], 3);
        chk(ads[0] == wba, "R4 writeback addr", ads[0], wba);
        chk(dts[0] == wbd, "R4 writeback data", dts[0], wbd);
        mem[wba] = dts[0];
        k = 1;
      end
      if (nt > k) begin
        chk(ops[k] == (wr ? 2'd2 : 2'd1), wr ? "R3 miss op" : "R2 miss op", ops[k], wr ? 2 : 1);
        chk(ads[k] == a, wr ? "R3 miss addr" : "R2 miss addr", ads[k], a);
        if (wr) chk(dts[k] == wd, "R3 miss data", dts[k], wd);
      end
      if (!wr) chk(rd == mem[a], "R2 fill data", rd, mem[a]);
      ref_st[ix] = wr ? 2'd2 : 2'd1;
      ref_tag[ix] = tg;
      ref_dat[ix] = wr ? wd : mem[a];
    end
  endtask

  task automatic snoop(input logic [1:0] op, input logic [7:0] a, input logic [15:0] other);
    logic [2:0] ix = a[2:0];
    bit m, es;
    string rq;
    while (bus_gnt) @(negedge clk);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    #1;
    m  = ref_st[ix] != 2'd0 && ref_tag[ix] == a[7:3];
    es = m && ref_st[ix] == 2'd2 && op != 2'd3;
    if (op == 2'd1) rq = es ? "R7 read-miss supply" : "R9 no effect";
    else if (op == 2'd2) rq = es ? "R8 write-miss supply" : (m ? "R6 invalidate" : "R9 no effect");
    else rq = "R9 writeback ignored";
    chk(snp_supply == es, rq, {31'b0, snp_supply}, {31'b0, es});
    if (es) chk(snp_data == ref_dat[ix], rq, snp_data, ref_dat[ix]);
    chk(!cpu_req_ready, "R11 blocked by snoop", {31'b0, cpu_req_ready}, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    if (es) mem[a] = ref_dat[ix];
    if (m && op == 2'd1 && ref_st[ix] == 2'd2) ref_st[ix] = 2'd1;
    if (m && op == 2'd2) ref_st[ix] = 2'd0;
    if (op == 2'd2) mem[a] = other;
  endtask

  initial begin
    logic [7:0] ra;
    int r;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5a3c;
    for (int i = 0; i < 8; i++) begin ref_st[i] = 2'd0; ref_tag[i] = '0; ref_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !cpu_rsp_valid && cpu_req_ready, "R1 reset outputs",
        {29'b0, bus_req, cpu_rsp_valid, cpu_req_ready}, 1);
    // directed
    cpu_op(0, 8'h00, 0);          // R1/R2 first access misses
    cpu_op(0, 8'h00, 0);          // R5 read hit in Shared
    cpu_op(1, 8'h00, 16'hbeef);   // R3 write to Shared
    cpu_op(1, 8'h00, 16'hcafe);   // R5 write hit in Modified
    cpu_op(0, 8'h00, 0);          // R5 read hit in Modified
    cpu_op(0, 8'h08, 0);          // R4 dirty victim written back
    snoop(2'd1, 8'h08, 0);        // R9 read miss on Shared
    snoop(2'd2, 8'h08, 16'h1111); // R6 invalidate
    cpu_op(0, 8'h08, 0);          // R6 line must miss again
    cpu_op(1, 8'h11, 16'h7777);
    snoop(2'd1, 8'h11, 0);        // R7 supply, drop to Shared
    cpu_op(1, 8'h11, 16'h8888);   // R7 write now misses
    snoop(2'd2, 8'h11, 16'h9999); // R8 supply, invalidate
    cpu_op(0, 8'h11, 0);          // R8 miss without writeback
    cpu_op(1, 8'h13, 16'h4242);
    snoop(2'd3, 8'h13, 0);        // R9 writeback ignored
    snoop(2'd2, 8'h1b, 16'h0);    // R9 tag mismatch
    cpu_op(0, 8'h13, 0);          // R9 still Modified hit
    // race: victim downgraded while the request waits for the grant (R10)
    cpu_op(1, 8'h22, 16'h3131);
    hold_gnt = 1'b1;
    fork
      cpu_op(0, 8'h2a, 0);
      begin
        repeat (3) @(negedge clk);
        snoop(2'd1, 8'h22, 0);
        hold_gnt = 1'b0;
      end
    join
    // random mix
    for (int i = 0; i < 400; i++) begin
      r  = int'($urandom % 10);
      ra = {3'b000, 2'($urandom % 4), 3'($urandom % 8)};
      if (r < 7) cpu_op(1'($urandom % 2), ra, 16'($urandom));
      else snoop(2'($urandom % 3) + 2'd1, ra, 16'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule